// File: doc/BRIEF.md
# Serial Receive Word Packer

This block sits between the receive shift register of a serial port and the DMA engine that moves received data into memory. Every word it hands on is 32 bits wide. A serial word of programmable length (3 to 32 bits, at least 8 bits when the channel runs in I2S framing) arrives right-justified on `rx_data`. Bits above the programmed length are cleared, so each word is zero-extended to 32 bits.

When packing is requested and the effective length is 16 bits or less, two consecutive serial words share one 32-bit output word. The earlier word goes in the low half and the later word in the high half. With DMA enabled, a level request is raised while an output word waits. With DMA disabled, a one-cycle interrupt pulse marks each output word, so packing halves the interrupt rate. The chaining enable is captured while the channel is idle and passed to the DMA controller. The output uses a valid/ready handshake. A word that completes while the output slot is still full is dropped, and a sticky overflow flag records the loss.

Top module: `rx_word_packer`

## Requirements
- R1: The effective length is `cfg_wlen` clamped to the range 3..32. An unpacked output word carries `rx_data` bits below the effective length, and every bit at or above it reads zero.
- R2: When `cfg_i2s` is 1, an effective length below 8 is raised to 8.
- R3: When `cfg_pack` is 1 and the effective length is 16 or less, two accepted words form one output word. The first word occupies bits 15:0 and the second occupies bits 31:16, each masked to the effective length. The first word alone produces no output.
- R4: When `cfg_pack` is 1 and the effective length exceeds 16, the pack setting is ignored and every word is output alone.
- R5: `irq` pulses for exactly one cycle, in the cycle `out_valid` is loaded with a new word, and only if `cfg_dma_en` was 0 when the word was accepted. `irq` stays 0 while DMA is enabled.
- R6: `dma_req` equals `out_valid` while `cfg_dma_en` is 1, and is 0 otherwise.
- R7: A half-filled pair is discarded when `cfg_en` is 0 at a clock edge, or when the DMA enable, the effective pack state or the effective length differs from its value at the previous edge. The next accepted word starts a new pair.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. When `out_ready` is 1 in the same cycle a new word completes, the new word replaces the old one.
- R9: A word that completes while `out_valid` is 1 and `out_ready` is 0 is dropped and sets `overflow`. `overflow` stays set until an edge with `cfg_en` at 0 clears it.
- R10: `chain_en` captures `cfg_chain` at every edge where `cfg_en` is 0, and holds its value while `cfg_en` is 1.
- R11: After reset, `out_valid`, `irq`, `dma_req`, `overflow` and `chain_en` are 0, and no half pair is pending.
- R12: `rx_valid` is ignored while `cfg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable |
| cfg_dma_en | input | 1 | 1: DMA request mode, 0: interrupt per output word |
| cfg_pack | input | 1 | Request packing of short words |
| cfg_i2s | input | 1 | I2S framing (minimum length 8) |
| cfg_chain | input | 1 | Chaining enable to be captured |
| cfg_wlen | input | 6 | Requested serial word length in bits |
| rx_valid | input | 1 | A received serial word is present |
| rx_data | input | 32 | Received word, right-justified |
| out_valid | output | 1 | Output word waiting |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Output word |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Per-word interrupt pulse |
| overflow | output | 1 | Sticky dropped-word flag |
| chain_en | output | 1 | Captured chaining enable |

## Verification
A stale pending half would appear as a wrong low half in the next packed word, or as an output one word early or late. Either shows on `out_data`/`out_valid` at the completion of the next pair, at most two accepted words later. A wrong length clamp shows up as extra or missing high bits on the very next output word. A lost handshake state shows as a changed `out_data` under back-pressure, or as a missing `overflow` one cycle after the drop. The bench compares every output on every cycle against a behavioural queue model, so any such divergence is caught in the cycle it first reaches a port.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LEN_W   = 6;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned MIN_LEN = 3;
  localparam int unsigned I2S_MIN = 8;

  typedef struct packed {
    logic             dma;
    logic             pack;
    logic [LEN_W-1:0] len;
  } mode_t;

  // limit a requested length to the legal range for the framing in use
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req,
                                                 input logic i2s);
    logic [LEN_W-1:0] l;
    l = req;
    if (l < LEN_W'(MIN_LEN)) l = LEN_W'(MIN_LEN);
    if (i2s && (l < LEN_W'(I2S_MIN))) l = LEN_W'(I2S_MIN);
    if (l > LEN_W'(WORD_W)) l = LEN_W'(WORD_W);
    return l;
  endfunction

  // ones in every bit position below len
  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < int'(WORD_W); i++) m[i] = (i < int'(len));
    return m;
  endfunction

  function automatic logic fits_half(input logic [LEN_W-1:0] len);
    return len <= LEN_W'(HALF_W);
  endfunction
endpackage

// File: rtl/rxp_cfg_decode.sv
module rxp_cfg_decode
  import rxp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_dma_en,
  input  logic             cfg_pack,
  input  logic             cfg_i2s,
  input  logic [LEN_W-1:0] cfg_wlen,
  output logic [LEN_W-1:0] eff_len,
  output logic             pack_act,
  output logic             flush
);
  mode_t cur_mode, prev_q;

  always_comb begin
    eff_len       = clamp_len(cfg_wlen, cfg_i2s);
    pack_act      = cfg_pack && fits_half(eff_len);
    cur_mode.dma  = cfg_dma_en;
    cur_mode.pack = pack_act;
    cur_mode.len  = eff_len;
    flush         = !cfg_en || (cur_mode != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_mode;
  end
endmodule

// File: rtl/rxp_pair_stage.sv
module rxp_pair_stage
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_in,
  input  logic [WORD_W-1:0] word_data,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic              pack_act,
  input  logic              flush,
  output logic              emit,
  output logic              emit_pair,
  output logic [WORD_W-1:0] emit_word,
  output logic              pending
);
  logic [HALF_W-1:0] low_q;
  logic [WORD_W-1:0] masked;
  logic              pend_live;
  logic              take_low;

  always_comb begin
    masked    = word_data & len_mask(eff_len);
    pend_live = pending && !flush;
    emit      = 1'b0;
    emit_pair = 1'b0;
    take_low  = 1'b0;
    emit_word = masked;
    if (word_in) begin
      if (pack_act) begin
        if (pend_live) begin
          emit      = 1'b1;
          emit_pair = 1'b1;
          emit_word = {masked[HALF_W-1:0], low_q};
        end else begin
          take_low  = 1'b1;
        end
      end else begin
        emit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      low_q   <= '0;
    end else if (take_low) begin
      pending <= 1'b1;
      low_q   <= masked[HALF_W-1:0];
    end else if (emit_pair || flush) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/rxp_out_slot.sv
module rxp_out_slot
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_dma_en,
  input  logic              emit,
  input  logic [WORD_W-1:0] emit_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              irq,
  output logic              overflow,
  output logic              drop
);
  logic blocked;
  logic load;

  assign blocked = out_valid && !out_ready;
  assign drop    = emit && blocked;
  assign load    = emit && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      irq       <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= emit_word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      irq <= load && !cfg_dma_en;
      if (!cfg_en)   overflow <= 1'b0;
      else if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxp_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned WLEN_W = LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_dma_en,
  input  logic              cfg_pack,
  input  logic              cfg_i2s,
  input  logic              cfg_chain,
  input  logic [WLEN_W-1:0] cfg_wlen,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              dma_req,
  output logic              irq,
  output logic              overflow,
  output logic              chain_en
);
  logic [LEN_W-1:0]  eff_len;
  logic              pack_act;
  logic              flush;
  logic              word_in;
  logic              emit;
  logic              emit_pair;
  logic [WORD_W-1:0] emit_word;
  logic              pending;
  logic              drop;

  assign word_in = rx_valid && cfg_en;

  rxp_cfg_decode u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dma_en(cfg_dma_en),
    .cfg_pack(cfg_pack), .cfg_i2s(cfg_i2s), .cfg_wlen(cfg_wlen),
    .eff_len(eff_len), .pack_act(pack_act), .flush(flush)
  );

  rxp_pair_stage u_pair (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_data(rx_data),
    .eff_len(eff_len), .pack_act(pack_act), .flush(flush),
    .emit(emit), .emit_pair(emit_pair), .emit_word(emit_word),
    .pending(pending)
  );

  rxp_out_slot u_out (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dma_en(cfg_dma_en),
    .emit(emit), .emit_word(emit_word), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .irq(irq),
    .overflow(overflow), .drop(drop)
  );

  assign dma_req = out_valid && cfg_dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain_en <= 1'b0;
    else if (!cfg_en) chain_en <= cfg_chain;
  end
endmodule

// File: rtl/rx_word_packer_chk.sv
module rx_word_packer_chk
  import rxp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_dma_en,
  input logic              rx_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              dma_req,
  input logic              irq,
  input logic              overflow,
  input logic              chain_en,
  input logic [LEN_W-1:0]  eff_len,
  input logic              pack_act,
  input logic              flush,
  input logic              emit,
  input logic              emit_pair,
  input logic [WORD_W-1:0] emit_word,
  input logic              pending,
  input logic              drop
);
  // R1
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !emit_pair |-> (emit_word & ~len_mask(eff_len)) == '0);
  // R4
  pend_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(pack_act));
  // R5
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(!cfg_dma_en) && out_valid);
  // R6
  dma_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> out_valid);
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !(rx_valid && cfg_en) |=> !pending);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop && cfg_en |=> overflow);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && cfg_en |=> overflow);
  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(chain_en));
endmodule

bind rx_word_packer rx_word_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dma_en(cfg_dma_en),
  .rx_valid(rx_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .dma_req(dma_req), .irq(irq), .overflow(overflow),
  .chain_en(chain_en), .eff_len(eff_len), .pack_act(pack_act),
  .flush(flush), .emit(emit), .emit_pair(emit_pair),
  .emit_word(emit_word), .pending(pending), .drop(drop)
);

// File: tb/rx_word_packer_tb.sv
module rx_word_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_dma_en = 1'b0, cfg_pack = 1'b0;
  logic        cfg_i2s = 1'b0, cfg_chain = 1'b0;
  logic [5:0]  cfg_wlen = 6'd8;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        out_ready = 1'b1;
  logic        out_valid, dma_req, irq, overflow, chain_en;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [31:0] m_out[$];
  logic [15:0] m_half[$];
  int          m_prev_key = -1;
  bit          m_irq = 0, m_ovf = 0, m_chain = 0;

  always #10 clk = ~clk;

  rx_word_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dma_en(cfg_dma_en),
    .cfg_pack(cfg_pack), .cfg_i2s(cfg_i2s), .cfg_chain(cfg_chain),
    .cfg_wlen(cfg_wlen), .rx_valid(rx_valid), .rx_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dma_req(dma_req), .irq(irq), .overflow(overflow), .chain_en(chain_en)
  );

  function automatic int ref_len(int req, bit i2s);
    int l = req;
    if (l < 3) l = 3;
    if (i2s && l < 8) l = 8;
    if (l > 32) l = 32;
    return l;
  endfunction

  function automatic logic [31:0] ref_keep(logic [31:0] v, int n);
    logic [63:0] one = 64'd1;
    logic [63:0] m = (one << n) - 64'd1;
    return v & m[31:0];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // advance the model by one clock edge using the inputs presented now
  task automatic model_edge();
    int  n   = ref_len(int'(cfg_wlen), cfg_i2s);
    bit  pk  = cfg_pack && (n <= 16);
    int  key = (cfg_dma_en ? 200 : 0) + (pk ? 100 : 0) + n;
    bit  done = 0;
    bit  full = (m_out.size() > 0) && !out_ready;
    logic [31:0] w = '0;
    logic [31:0] v;
    if (!cfg_en || key != m_prev_key) m_half.delete();
    m_prev_key = key;
    if (cfg_en && rx_valid) begin
      v = ref_keep(rx_data, n);
      if (!pk) begin
        w = v; done = 1;
      end else if (m_half.size() == 0) begin
        m_half.push_back(v[15:0]);
      end else begin
        w = {v[15:0], m_half.pop_front()}; done = 1;
      end
    end
    if (m_out.size() > 0 && out_ready) void'(m_out.pop_front());
    m_irq = 0;
    if (done) begin
      if (full) m_ovf = 1;
      else begin
        m_out.push_back(w);
        m_irq = !cfg_dma_en;
      end
    end
    if (!cfg_en) begin
      m_ovf   = 0;
      m_chain = cfg_chain;
    end
  endtask

  task automatic compare_all();
    bit ev = (m_out.size() > 0);
    check("R8", "out_valid", {31'd0, out_valid}, {31'd0, ev});
    if (ev) check("R1 R2 R3 R4 R7 R12", "out_data", out_data, m_out[0]);
    check("R5", "irq", {31'd0, irq}, {31'd0, m_irq});
    check("R6", "dma_req", {31'd0, dma_req}, {31'd0, ev && cfg_dma_en});
    check("R9", "overflow", {31'd0, overflow}, {31'd0, m_ovf});
    check("R10", "chain_en", {31'd0, chain_en}, {31'd0, m_chain});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic send(logic [31:0] d);
    rx_valid = 1'b1; rx_data = d;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic setup(bit en, bit dma, bit pk, bit i2s, int len);
    cfg_en = en; cfg_dma_en = dma; cfg_pack = pk; cfg_i2s = i2s;
    cfg_wlen = 6'(len);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R11", "irq", {31'd0, irq}, 32'd0);
    check("R11", "overflow", {31'd0, overflow}, 32'd0);
    check("R11", "chain_en", {31'd0, chain_en}, 32'd0);
    check("R11", "dma_req", {31'd0, dma_req}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R12: words ignored while disabled
    send(32'hDEAD_BEEF); send(32'h1234_5678); tick();

    // R1: unpacked, DMA mode, several lengths incl. clamps
    setup(1, 1, 0, 0, 12);
    send(32'hFFFF_FFFF); send(32'hA5A5_A5A5); tick();
    setup(1, 1, 0, 0, 2);  send(32'hFFFF_FFFF); tick();
    setup(1, 1, 0, 0, 40); send(32'hCAFE_F00D); tick();
    setup(1, 0, 0, 0, 32); send(32'h8000_0001); tick();

    // R2: I2S minimum length
    setup(1, 0, 0, 1, 5); send(32'hFFFF_FFFF); tick();
    setup(1, 0, 0, 1, 20); send(32'hFFFF_FFFF); tick();

    // R3 R5: packing with interrupts
    setup(1, 0, 1, 0, 16);
    send(32'h0000_1111); send(32'h0000_2222); tick();
    setup(1, 0, 1, 0, 10);
    send(32'hFFFF_FFFF); send(32'h0000_0155); send(32'h0000_03AA); tick();

    // R4: pack ignored above 16 bits
    setup(1, 1, 1, 0, 20);
    send(32'h000F_FFFF); send(32'hFFF1_2345); tick();

    // R7: flush by length change and by disable
    setup(1, 0, 1, 0, 8);
    send(32'h0000_00AB);
    cfg_wlen = 6'd9; send(32'h0000_01CD); send(32'h0000_01EF); tick();
    send(32'h0000_0011);
    setup(0, 0, 1, 0, 9);
    setup(1, 0, 1, 0, 9); send(32'h22); send(32'h33); tick();

    // R8 R9: back-pressure and overflow
    out_ready = 1'b0;
    setup(1, 1, 0, 0, 16);
    send(32'h1); send(32'h2); send(32'h3); tick(); tick();
    out_ready = 1'b1; tick();
    send(32'h4); tick();
    setup(0, 1, 0, 0, 16);

    // R10: chaining enable captured only while idle
    cfg_chain = 1'b1; tick();
    cfg_en = 1'b1; tick(); cfg_chain = 1'b0; tick(); tick();
    cfg_en = 1'b0; tick(); tick();

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        cfg_en     = ($urandom_range(0, 7) != 0);
        cfg_dma_en = $urandom_range(0, 1);
        cfg_pack   = $urandom_range(0, 1);
        cfg_i2s    = $urandom_range(0, 1);
        cfg_chain  = $urandom_range(0, 1);
        cfg_wlen   = 6'($urandom_range(0, 40));
      end
      rx_valid  = $urandom_range(0, 2) != 0;
      rx_data   = $urandom;
      out_ready = $urandom_range(0, 3) != 0;
      tick();
    end
    rx_valid = 1'b0; out_ready = 1'b1; tick(); tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule